// File: doc/BRIEF.md
# ULPI PHY Register Read Responder

This block is the transceiver-side responder for register reads on an 8-bit ULPI bus. It watches the byte the Link drives and picks out read commands. When it sees one, it runs the handshake: it accepts the command with NXT, takes over the bus with DIR, and spends one turnaround cycle. It then drives the requested register value for one cycle and hands the bus back to the Link.

One reserved immediate address works as an escape. When the command carries it, the responder accepts one more byte, and that byte is an 8-bit address into a second, extended register space. The register contents are constants computed at elaboration. Register writes, packet traffic and receive status commands are handled elsewhere.

Every output is decoded from a registered state, so it changes one clock edge after the input that caused it.

Top module: `ulpi_rd_responder`

## Requirements
- R1: While `rst` is high at a clock edge, in the following cycle `dir`, `nxt` and `data_oe` are 0 and `data_out` is 8'h00.
- R2: In the idle state, a byte on `data_in` with bits 7:6 equal to 2'b11 starts a read, and bits 5:0 are the immediate address. Any other byte, including the idle byte 8'h00 and the 2'b01 and 2'b10 prefixes, leaves all outputs low.
- R3: For an immediate read whose command is on the bus in cycle T0, `nxt` is high in cycle T2 only.
- R4: `dir` rises in the cycle after the last `nxt`-high cycle, and `nxt` is low in every `dir`-high cycle. The first `dir`-high cycle is a turnaround in which `data_oe` stays low.
- R5: In the cycle after the turnaround, `data_oe` is high and `data_out` carries the register value. In the next cycle `dir` and `data_oe` are both low, so there is exactly one data cycle per read.
- R6: For an immediate address a < NUM_IMM (default 16), the register value is (7*a + 8'h11) mod 256. For an extended address e < NUM_EXT (default 8), it is 8'hC0 XOR (5*e). Every other address reads as 8'h00.
- R7: The immediate address 6'h2F selects the extended space. `nxt` is high in T2 and T3, and the byte on `data_in` in T3 is the 8-bit extended address. `dir` is high in T4 (turnaround) and T5 (data), and low from T6.
- R8: If `stp` is high in any cycle from T1 up to and including the last `nxt`-high cycle, the read is abandoned. `nxt` and `dir` are low in the next cycle, and the responder waits for a new command.
- R9: `data_out` is 8'h00 whenever `data_oe` is low, and `data_oe` is high only while `dir` is high.
- R10: Once `dir` has fallen, the responder is idle, and a command placed on the bus in that same cycle or any later cycle starts a new read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 8 | Byte driven by the Link |
| stp | input | 1 | Link stop request |
| dir | output | 1 | Bus direction, high while the responder owns the bus |
| nxt | output | 1 | Command or address byte accepted |
| data_out | output | 8 | Byte driven by the responder |
| data_oe | output | 1 | Enable for `data_out` onto the bus |

## Verification
For an immediate read whose command is on the bus in cycle T0, `nxt` is due in T2, `dir` in T3 and T4, the data byte in T4, and everything is low again in T5. An extended read moves each of these one cycle later, because of the extra address cycle. An abort shows up one cycle after the `stp` cycle. The reference model in the bench advances a cycle counter on each rising edge from the inputs it samples there. Outputs are compared with that counter's expectations at every falling edge, before the next inputs are applied, so each result is checked in exactly the cycle it is due.

// File: rtl/ulpi_rd_pkg.sv
package ulpi_rd_pkg;

    localparam logic [1:0] READ_PREFIX = 2'b11;
    localparam logic [5:0] EXT_ESCAPE  = 6'h2F;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_ACK,
        ST_EXT,
        ST_TURN,
        ST_DATA
    } rd_state_e;

    typedef struct packed {
        logic       is_read;
        logic       is_ext;
        logic [5:0] addr;
    } rd_cmd_t;

    typedef struct packed {
        logic dir;
        logic nxt;
        logic oe;
    } bus_ctl_t;

    function automatic rd_cmd_t decode_byte(input logic [7:0] b);
        rd_cmd_t c;
        c.is_read = (b[7:6] == READ_PREFIX);
        c.is_ext  = c.is_read && (b[5:0] == EXT_ESCAPE);
        c.addr    = b[5:0];
        return c;
    endfunction

    function automatic logic [7:0] imm_value(input int a);
        return 8'((a * 7 + 17) & 255);
    endfunction

    function automatic logic [7:0] ext_value(input int e);
        return 8'h C0 ^ 8'((e * 5) & 255);
    endfunction

endpackage

// File: rtl/ulpi_rd_decode.sv
module ulpi_rd_decode
    import ulpi_rd_pkg::*;
(
    input  logic [7:0] bus_byte,
    output rd_cmd_t    cmd
);
    always_comb cmd = decode_byte(bus_byte);
endmodule

// File: rtl/ulpi_rd_regfile.sv
module ulpi_rd_regfile
    import ulpi_rd_pkg::*;
#(
    parameter int NUM_IMM = 16,
    parameter int NUM_EXT = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       is_ext,
    input  logic [7:0] addr,
    output logic [7:0] rdata
);
    logic [7:0] imm_tab [NUM_IMM];
    logic [7:0] ext_tab [NUM_EXT];
    logic [7:0] lookup;

    for (genvar i = 0; i < NUM_IMM; i++) begin : g_imm
        assign imm_tab[i] = imm_value(i);
    end
    for (genvar j = 0; j < NUM_EXT; j++) begin : g_ext
        assign ext_tab[j] = ext_value(j);
    end

    always_comb begin
        lookup = 8'h00;
        if (is_ext) begin
            for (int k = 0; k < NUM_EXT; k++)
                if (int'(addr) == k) lookup = ext_tab[k];
        end else begin
            for (int k = 0; k < NUM_IMM; k++)
                if (int'(addr) == k) lookup = imm_tab[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       rdata <= 8'h00;
        else if (load) rdata <= lookup;
    end
endmodule

// File: rtl/ulpi_rd_fsm.sv
module ulpi_rd_fsm
    import ulpi_rd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] data_in,
    input  logic       stp,
    input  rd_cmd_t    cmd,
    output bus_ctl_t   ctl,
    output logic       load,
    output logic       sel_ext,
    output logic [7:0] sel_addr
);
    rd_state_e  state;
    logic       ext_q;
    logic [5:0] addr_q;
    logic [7:0] eaddr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ext_q   <= 1'b0;
            addr_q  <= '0;
            eaddr_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (cmd.is_read) begin
                    state  <= ST_HOLD;
                    ext_q  <= cmd.is_ext;
                    addr_q <= cmd.addr;
                end
                ST_HOLD: state <= stp ? ST_IDLE : ST_ACK;
                ST_ACK:  state <= stp ? ST_IDLE : (ext_q ? ST_EXT : ST_TURN);
                ST_EXT: begin
                    if (stp) state <= ST_IDLE;
                    else begin
                        state   <= ST_TURN;
                        eaddr_q <= data_in;
                    end
                end
                ST_TURN: state <= ST_DATA;
                ST_DATA: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.nxt  = (state == ST_ACK) || (state == ST_EXT);
        ctl.dir  = (state == ST_TURN) || (state == ST_DATA);
        ctl.oe   = (state == ST_DATA);
        load     = (state == ST_TURN);
        sel_ext  = ext_q;
        sel_addr = ext_q ? eaddr_q : {2'b00, addr_q};
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!ctl.dir && !ctl.nxt && !ctl.oe));
    a_r4_no_nxt_with_dir: assert property (@(posedge clk) disable iff (rst)
        ctl.dir |-> !ctl.nxt);
    a_r4_turnaround_first: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.dir) |-> (!ctl.oe && $past(ctl.nxt)));
    a_r5_single_data: assert property (@(posedge clk) disable iff (rst)
        ctl.oe |=> (!ctl.dir && !ctl.oe));
    a_r8_stp_abort: assert property (@(posedge clk) disable iff (rst)
        (ctl.nxt && stp) |=> (!ctl.dir && !ctl.nxt));
    a_r9_oe_needs_dir: assert property (@(posedge clk) disable iff (rst)
        ctl.oe |-> ctl.dir);
endmodule

// File: rtl/ulpi_rd_responder.sv
module ulpi_rd_responder
    import ulpi_rd_pkg::*;
#(
    parameter int NUM_IMM = 16,
    parameter int NUM_EXT = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] data_in,
    input  logic       stp,
    output logic       dir,
    output logic       nxt,
    output logic [7:0] data_out,
    output logic       data_oe
);
    rd_cmd_t    cmd;
    bus_ctl_t   ctl;
    logic       load;
    logic       sel_ext;
    logic [7:0] sel_addr;
    logic [7:0] rdata;

    ulpi_rd_decode u_decode (
        .bus_byte (data_in),
        .cmd      (cmd)
    );

    ulpi_rd_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .data_in  (data_in),
        .stp      (stp),
        .cmd      (cmd),
        .ctl      (ctl),
        .load     (load),
        .sel_ext  (sel_ext),
        .sel_addr (sel_addr)
    );

    ulpi_rd_regfile #(.NUM_IMM(NUM_IMM), .NUM_EXT(NUM_EXT)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .is_ext (sel_ext),
        .addr   (sel_addr),
        .rdata  (rdata)
    );

    assign dir      = ctl.dir;
    assign nxt      = ctl.nxt;
    assign data_oe  = ctl.oe;
    assign data_out = ctl.oe ? rdata : 8'h00;

    a_r9_data_zero_idle: assert property (@(posedge clk) disable iff (rst)
        !data_oe |-> (data_out == 8'h00));
endmodule

// File: tb/ulpi_rd_responder_tb.sv
module ulpi_rd_responder_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] data_in = 8'h00;
    logic       stp = 1'b0;
    logic       dir, nxt, data_oe;
    logic [7:0] data_out;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;
    string cur_tag = "R1";

    always #4 clk = ~clk;

    ulpi_rd_responder u_dut (
        .clk(clk), .rst(rst), .data_in(data_in), .stp(stp),
        .dir(dir), .nxt(nxt), .data_out(data_out), .data_oe(data_oe)
    );

    // R6 register values, written from the requirement
    function automatic logic [7:0] ref_value(bit ext, int a);
        if (!ext) return (a < 16) ? 8'((7 * a + 17) % 256) : 8'h00;
        return (a < 8) ? (8'hC0 ^ 8'((5 * a) % 256)) : 8'h00;
    endfunction

    // behavioural reference: cycle number inside the current read, 0 = idle
    int  m_cyc = 0;
    bit  m_ext = 0;
    int  m_addr = 0;
    int  m_eaddr = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_cyc = 0;
        end else if (m_cyc == 0) begin
            if (data_in[7:6] == 2'b11) begin
                m_cyc  = 1;
                m_addr = int'(data_in[5:0]);
                m_ext  = (data_in[5:0] == 6'h2F);
            end
        end else begin
            if (stp && m_cyc <= (m_ext ? 3 : 2)) begin
                m_cyc = 0;
            end else begin
                if (m_ext && m_cyc == 3) m_eaddr = int'(data_in);
                m_cyc++;
                if (m_cyc > (m_ext ? 5 : 4)) m_cyc = 0;
            end
        end
    end

    task automatic compare();
        int   last_nxt = m_ext ? 3 : 2;
        logic e_nxt = (m_cyc == 2) || (m_ext && m_cyc == 3);
        logic e_dir = (m_cyc == last_nxt + 1) || (m_cyc == last_nxt + 2);
        logic e_oe  = (m_cyc == last_nxt + 2);
        logic [7:0] e_dat = e_oe ? ref_value(m_ext, m_ext ? m_eaddr : m_addr) : 8'h00;
        vectors++;
        if ({nxt, dir, data_oe, data_out} !== {e_nxt, e_dir, e_oe, e_dat}) begin
            fails++;
            $display("FAIL %s: nxt/dir/oe/data = %b/%b/%b/%h expected %b/%b/%b/%h",
                     cur_tag, nxt, dir, data_oe, data_out, e_nxt, e_dir, e_oe, e_dat);
        end
    endtask

    task automatic step(logic [7:0] d, logic s);
        @(negedge clk);
        compare();
        data_in = d;
        stp     = s;
    endtask

    // cycles k = 0..len-1; command held in T0..T2, extended byte in T3
    task automatic do_read(logic [7:0] cmd, logic [7:0] ext, int stp_at, int len);
        bit aborted = 0;
        for (int k = 0; k < len; k++) begin
            logic [7:0] d = 8'h00;
            if (!aborted && k <= 2) d = cmd;
            if (!aborted && k == 3) d = ext;
            step(d, k == stp_at);
            if (k == stp_at) aborted = 1;
        end
    endtask

    initial begin
        @(posedge clk);
        cur_tag = "R1 reset";
        for (int i = 0; i < 3; i++) step(8'h00, 1'b0);
        rst = 1'b0;
        cur_tag = "R2 idle byte ignored";
        for (int i = 0; i < 4; i++) step(8'h00, 1'b0);
        cur_tag = "R2 non-read prefixes ignored";
        step(8'h40, 1'b0); step(8'h80, 1'b0); step(8'h15, 1'b0);
        step(8'h7F, 1'b0); step(8'hBF, 1'b0); step(8'h00, 1'b0);
        step(8'h00, 1'b0);
        cur_tag = "R3 R4 R5 immediate read";
        do_read(8'hC0, 8'h00, -1, 8);
        do_read(8'hC5, 8'h00, -1, 8);
        cur_tag = "R6 immediate values";
        do_read(8'hCF, 8'h00, -1, 8);
        do_read(8'hD0, 8'h00, -1, 8);
        do_read(8'hFF, 8'h00, -1, 8);
        cur_tag = "R7 extended read";
        do_read(8'hEF, 8'h00, -1, 8);
        do_read(8'hEF, 8'h07, -1, 8);
        cur_tag = "R6 R7 extended unimplemented";
        do_read(8'hEF, 8'h08, -1, 8);
        do_read(8'hEF, 8'hFF, -1, 8);
        cur_tag = "R8 stp abort";
        do_read(8'hC3, 8'h00, 1, 6);
        do_read(8'hC3, 8'h00, 2, 6);
        do_read(8'hEF, 8'h02, 3, 7);
        do_read(8'hEF, 8'h02, 2, 7);
        cur_tag = "R8 stp after dir ignored";
        do_read(8'hC4, 8'h00, 3, 7);
        cur_tag = "R10 back to back";
        do_read(8'hC1, 8'h00, -1, 5);
        do_read(8'hEF, 8'h03, -1, 6);
        do_read(8'hC9, 8'h00, -1, 8);
        cur_tag = "R9 quiet tail";
        for (int i = 0; i < 4; i++) step(8'h00, 1'b0);
        cur_tag = "R1 reset mid read";
        step(8'hC2, 1'b0); step(8'hC2, 1'b0);
        rst = 1'b1;
        step(8'h00, 1'b0);
        rst = 1'b0;
        step(8'h00, 1'b0); step(8'h00, 1'b0);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: run still active, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule